// File: doc/BRIEF.md
# CAN Transmit Buffer Move-Out Controller

This block sits between a small array of host-written CAN message buffers and a bit-level transmit engine. At each opportunity it finds the lowest-numbered buffer that is marked ready to send. It copies that buffer's identifier, length and payload into a private staging register. It then raises a transmit request towards the engine, which answers with one of three single-cycle pulses: done, arbitration lost or error.

When the abort-enable input is high, the buffer that has been copied out is write-locked. Ordinary host writes to it are dropped, and a sticky indicator records that one was attempted. The lock is released when the frame is sent, when the engine reports a lost arbitration or an error, or when the controller is halted or bus-off. The host can cancel a transmission by writing the abort code. If the buffer has not been copied out, the cancel completes at once. If it has, the cancel waits for the engine's outcome.

Top module: `can_txmo_top`

## Requirements
- R1: Buffer code 4'b1100 means ready to send. With nothing staged and both halt and bus_off low, the ready buffer with the lowest index is staged on the next clock edge. tx_req then goes high and tx_src holds that index.
- R2: The staged copy shows the buffer's ID on tx_id. tx_len is min(DLC, 8). tx_data carries payload byte k in bits [8k+7:8k], and every byte at or above tx_len reads as zero.
- R3: With aen high, the staged source buffer is locked (its bit in lock_vec is set). A write to it with any code other than 4'b1001 leaves it unchanged, and blocked_seen goes high and stays high until reset.
- R4: With aen low, no lock is taken and host writes to the staged buffer land. A tx_done for a buffer rewritten to the inactive code 4'b1000 sets no flag.
- R5: On tx_done, a staged buffer whose code is 4'b1100 or 4'b1001 returns to 4'b1000 and gets its irq_flag bit set. In the same edge the lock is released and tx_req drops.
- R6: On tx_arb_lost or tx_err, staging and the lock are released. A buffer still coded 4'b1100 keeps its code and is staged again on the following edge.
- R7: While halt or bus_off is high, any staged frame and its lock are released and no new buffer is staged.
- R8: With aen high, writing code 4'b1001 to a buffer that is not staged sets its code to 4'b1000 and sets its irq_flag bit on the same edge.
- R9: With aen high, writing 4'b1001 to the staged buffer stores 4'b1001 and keeps tx_req. The next tx_done, tx_arb_lost or tx_err then sets the code to 4'b1000 and sets the flag.
- R10: Each set bit of flag_clr clears the matching irq_flag bit. A flag set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aen | input | 1 | Abort and lock enable |
| halt | input | 1 | Controller halted |
| bus_off | input | 1 | Controller bus-off |
| wr_en | input | 1 | Host buffer write strobe |
| wr_idx | input | 2 | Buffer index to write |
| wr_code | input | 4 | Code written |
| wr_id | input | 11 | Identifier written |
| wr_dlc | input | 4 | Data length code written |
| wr_data | input | 64 | Payload written, byte 0 in the low bits |
| flag_clr | input | 4 | Write-one-to-clear for irq_flag |
| rd_idx | input | 2 | Buffer index for code readback |
| rd_code | output | 4 | Code of buffer rd_idx |
| irq_flag | output | 4 | Per-buffer completion flags |
| lock_vec | output | 4 | Per-buffer write-lock state |
| blocked_seen | output | 1 | Sticky: a write to a locked buffer was dropped |
| tx_req | output | 1 | Staged frame awaiting the engine |
| tx_src | output | 2 | Index of the staged buffer |
| tx_id | output | 11 | Staged identifier |
| tx_len | output | 4 | Staged byte count, at most 8 |
| tx_data | output | 64 | Staged payload, unused bytes zero |
| tx_done | input | 1 | Engine: frame sent |
| tx_arb_lost | input | 1 | Engine: arbitration lost |
| tx_err | input | 1 | Engine: transmit error |

## Verification
The assertions assume the engine pulses tx_done, tx_arb_lost and tx_err only while tx_req is high. They also assume that aen stays steady while a frame is staged. The stimulus never writes a buffer in the same cycle in which it is being selected. It changes aen only when nothing is staged, and it raises each engine pulse for a single cycle while a frame is staged.

// File: rtl/can_txmo_pkg.sv
package can_txmo_pkg;
    typedef logic [3:0] code_t;
    localparam code_t CODE_RX_OFF   = 4'b0000;
    localparam code_t CODE_TX_OFF   = 4'b1000;
    localparam code_t CODE_TX_ABORT = 4'b1001;
    localparam code_t CODE_TX_READY = 4'b1100;
    localparam int    MAX_BYTES     = 8;
endpackage

// File: rtl/can_txmo_pick.sv
module can_txmo_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_txmo_stage.sv
module can_txmo_stage
    import can_txmo_pkg::*;
#(
    parameter int ID_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [ID_W-1:0]        ld_id,
    input  logic [3:0]             ld_dlc,
    input  logic [MAX_BYTES*8-1:0] ld_data,
    output logic [ID_W-1:0]        st_id,
    output logic [3:0]             st_len,
    output logic [MAX_BYTES*8-1:0] st_data
);
    typedef struct packed {
        logic [ID_W-1:0]        id;
        logic [3:0]             len;
        logic [MAX_BYTES*8-1:0] data;
    } stg_t;

    stg_t stg_d, stg_q;
    logic [3:0]             clamp_len;
    logic [MAX_BYTES*8-1:0] masked;

    assign clamp_len = (ld_dlc > 4'(MAX_BYTES)) ? 4'(MAX_BYTES) : ld_dlc;

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        assign masked[b*8 +: 8] = (4'(b) < clamp_len) ? ld_data[b*8 +: 8] : 8'h00;
    end

    always_comb begin
        stg_d = stg_q;
        if (load) begin
            stg_d.id   = ld_id;
            stg_d.len  = clamp_len;
            stg_d.data = masked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign st_id   = stg_q.id;
    assign st_len  = stg_q.len;
    assign st_data = stg_q.data;

    // R2
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_len <= 4'(MAX_BYTES));
endmodule

// File: rtl/can_txmo_top.sv
module can_txmo_top
    import can_txmo_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int ID_W   = 11,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int DW    = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aen,
    input  logic              halt,
    input  logic              bus_off,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [3:0]        wr_code,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [3:0]        wr_dlc,
    input  logic [DW-1:0]     wr_data,
    input  logic [NUM_MB-1:0] flag_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [3:0]        rd_code,
    output logic [NUM_MB-1:0] irq_flag,
    output logic [NUM_MB-1:0] lock_vec,
    output logic              blocked_seen,
    output logic              tx_req,
    output logic [IDX_W-1:0]  tx_src,
    output logic [ID_W-1:0]   tx_id,
    output logic [3:0]        tx_len,
    output logic [DW-1:0]     tx_data,
    input  logic              tx_done,
    input  logic              tx_arb_lost,
    input  logic              tx_err
);
    typedef struct packed {
        logic [NUM_MB-1:0][3:0]      code;
        logic [NUM_MB-1:0][ID_W-1:0] id;
        logic [NUM_MB-1:0][3:0]      dlc;
        logic [NUM_MB-1:0][DW-1:0]   data;
        logic [NUM_MB-1:0]           flag;
        logic [NUM_MB-1:0]           lock;
        logic                        stg_valid;
        logic [IDX_W-1:0]            stg_idx;
        logic                        blocked;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_MB-1:0] ready;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              load;
    logic              stop;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_rdy
        assign ready[i] = (st_q.code[i] == CODE_TX_READY);
    end

    can_txmo_pick #(.N(NUM_MB), .IDX_W(IDX_W)) i_pick (
        .req   (ready),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign stop = halt | bus_off;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        st_d.flag = st_q.flag & ~flag_clr;

        if (wr_en && (32'(wr_idx) < NUM_MB)) begin
            if (aen && wr_code == CODE_TX_ABORT) begin
                if (st_q.stg_valid && wr_idx == st_q.stg_idx) begin
                    st_d.code[wr_idx] = CODE_TX_ABORT;
                end else begin
                    st_d.code[wr_idx] = CODE_TX_OFF;
                    st_d.flag[wr_idx] = 1'b1;
                end
            end else if (st_q.lock[wr_idx]) begin
                st_d.blocked = 1'b1;
            end else begin
                st_d.code[wr_idx] = wr_code;
                st_d.id[wr_idx]   = wr_id;
                st_d.dlc[wr_idx]  = wr_dlc;
                st_d.data[wr_idx] = wr_data;
            end
        end

        if (st_q.stg_valid) begin
            if (tx_done) begin
                if (st_d.code[st_q.stg_idx] == CODE_TX_READY ||
                    st_d.code[st_q.stg_idx] == CODE_TX_ABORT) begin
                    st_d.code[st_q.stg_idx] = CODE_TX_OFF;
                    st_d.flag[st_q.stg_idx] = 1'b1;
                end
                st_d.stg_valid = 1'b0;
                st_d.lock      = '0;
            end else if (tx_arb_lost || tx_err || stop) begin
                if (st_d.code[st_q.stg_idx] == CODE_TX_ABORT) begin
                    st_d.code[st_q.stg_idx] = CODE_TX_OFF;
                    st_d.flag[st_q.stg_idx] = 1'b1;
                end
                st_d.stg_valid = 1'b0;
                st_d.lock      = '0;
            end
        end else if (!stop && pick_found) begin
            load                 = 1'b1;
            st_d.stg_valid       = 1'b1;
            st_d.stg_idx         = pick_idx;
            st_d.lock[pick_idx]  = aen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    can_txmo_stage #(.ID_W(ID_W)) i_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_id   (st_q.id[pick_idx]),
        .ld_dlc  (st_q.dlc[pick_idx]),
        .ld_data (st_q.data[pick_idx]),
        .st_id   (tx_id),
        .st_len  (tx_len),
        .st_data (tx_data)
    );

    assign rd_code      = st_q.code[rd_idx];
    assign irq_flag     = st_q.flag;
    assign lock_vec     = st_q.lock;
    assign blocked_seen = st_q.blocked;
    assign tx_req       = st_q.stg_valid;
    assign tx_src       = st_q.stg_idx;

    // R3
    lock_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lock_vec));
    // R3
    lock_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lock_vec) |-> tx_req);
    // R3
    blocked_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_seen |=> blocked_seen);
    // R4
    no_lock_wo_aen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!aen && !tx_req) |=> (lock_vec == '0));
    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done) |=> (!tx_req && lock_vec == '0));
    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt || bus_off) |=> !tx_req);
    // R1
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done && !tx_arb_lost && !tx_err && !halt && !bus_off)
        |=> (tx_req && $stable(tx_src)));
endmodule

// File: tb/test_can_txmo_top.sv
module test_can_txmo_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aen = 1'b1, halt = 1'b1, bus_off = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [3:0]  wr_code = '0;
    logic [10:0] wr_id = '0;
    logic [3:0]  wr_dlc = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  flag_clr = '0;
    logic [1:0]  rd_idx = '0;
    logic [3:0]  rd_code;
    logic [3:0]  irq_flag, lock_vec;
    logic        blocked_seen, tx_req;
    logic [1:0]  tx_src;
    logic [10:0] tx_id;
    logic [3:0]  tx_len;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0, tx_arb_lost = 1'b0, tx_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    can_txmo_top i_can_txmo_top (
        .clk(clk), .rst_n(rst_n), .aen(aen), .halt(halt), .bus_off(bus_off),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code), .wr_id(wr_id),
        .wr_dlc(wr_dlc), .wr_data(wr_data), .flag_clr(flag_clr),
        .rd_idx(rd_idx), .rd_code(rd_code), .irq_flag(irq_flag),
        .lock_vec(lock_vec), .blocked_seen(blocked_seen), .tx_req(tx_req),
        .tx_src(tx_src), .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data),
        .tx_done(tx_done), .tx_arb_lost(tx_arb_lost), .tx_err(tx_err)
    );

    // {ready mask, dlc, expected source, expected length}
    localparam logic [13:0] VEC [0:5] = '{
        {4'b1111, 4'd5,  2'd0, 4'd5},
        {4'b1110, 4'd12, 2'd1, 4'd8},
        {4'b1100, 4'd8,  2'd2, 4'd8},
        {4'b1000, 4'd0,  2'd3, 4'd0},
        {4'b1010, 4'd15, 2'd1, 4'd8},
        {4'b0100, 4'd3,  2'd2, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [3:0] code,
                      input logic [10:0] id, input logic [3:0] dlc,
                      input logic [63:0] data);
        wr_en = 1'b1; wr_idx = idx; wr_code = code;
        wr_id = id; wr_dlc = dlc; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic code_of(input logic [1:0] idx, output logic [3:0] c);
        rd_idx = idx;
        #1;
        c = rd_code;
    endtask

    task automatic pulse(input int which);
        if (which == 0) tx_done = 1'b1;
        else if (which == 1) tx_arb_lost = 1'b1;
        else tx_err = 1'b1;
        @(negedge clk);
        tx_done = 1'b0; tx_arb_lost = 1'b0; tx_err = 1'b0;
    endtask

    task automatic all_off();
        for (int i = 0; i < 4; i++) wr(2'(i), 4'b1000, '0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!tx_req && irq_flag == 0 && lock_vec == 0 && !blocked_seen, "R1",
            "reset outputs", {tx_req, irq_flag, lock_vec, blocked_seen}, '0);
        code_of(2'd2, c);
        chk(c == 4'b0000, "R1", "reset code", c, 0);

        // priority table: R1, R2
        for (int v = 0; v < 6; v++) begin
            halt = 1'b1;
            for (int i = 0; i < 4; i++)
                wr(2'(i), VEC[v][13-(3-i)] ? 4'b1100 : 4'b1000,
                   11'(i), VEC[v][9:6], 64'hFFFF_FFFF_FFFF_FFFF);
            halt = 1'b0;
            @(negedge clk);
            chk(tx_req && tx_src == VEC[v][5:4], "R1", "priority source",
                tx_src, VEC[v][5:4]);
            chk(tx_len == VEC[v][3:0], "R2", "clamped length", tx_len, VEC[v][3:0]);
            halt = 1'b1;
            @(negedge clk);
        end

        // R3 lock and blocked write
        all_off();
        flag_clr = 4'hF; @(negedge clk); flag_clr = 0;
        aen = 1'b1;
        wr(2'd1, 4'b1100, 11'h12, 4'd2, 64'h1);
        halt = 1'b0;
        @(negedge clk);
        chk(tx_req && lock_vec == 4'b0010, "R3", "lock taken", lock_vec, 4'b0010);
        wr(2'd1, 4'b1000, 11'h0, 4'd0, 64'h0);
        code_of(2'd1, c);
        chk(c == 4'b1100 && blocked_seen, "R3", "locked write dropped",
            {blocked_seen, c}, {1'b1, 4'b1100});

        // R5 done
        pulse(0);
        code_of(2'd1, c);
        chk(!tx_req && c == 4'b1000 && irq_flag[1] && lock_vec == 0, "R5",
            "done completion", {tx_req, c, irq_flag, lock_vec},
            {1'b0, 4'b1000, 4'b0010, 4'b0000});
        flag_clr = 4'b0010; @(negedge clk); flag_clr = 0;
        chk(irq_flag[1] == 1'b0, "R10", "flag cleared", irq_flag, 0);

        // R6 arbitration lost, then R9 abort completed by error
        wr(2'd2, 4'b1100, 11'h22, 4'd1, 64'h2);
        @(negedge clk);
        chk(tx_req && tx_src == 2, "R6", "staged buf2", tx_src, 2);
        pulse(1);
        code_of(2'd2, c);
        chk(!tx_req && lock_vec == 0 && c == 4'b1100, "R6", "arb lost release",
            {tx_req, lock_vec, c}, {1'b0, 4'b0000, 4'b1100});
        @(negedge clk);
        chk(tx_req && tx_src == 2, "R6", "restaged", {tx_req, tx_src}, {1'b1, 2'd2});
        wr(2'd2, 4'b1001, 11'h0, 4'd0, 64'h0);
        code_of(2'd2, c);
        chk(tx_req && c == 4'b1001, "R9", "abort pending", {tx_req, c}, {1'b1, 4'b1001});
        pulse(2);
        code_of(2'd2, c);
        chk(!tx_req && c == 4'b1000 && irq_flag[2], "R9", "abort by error",
            {tx_req, c, irq_flag}, {1'b0, 4'b1000, 4'b0100});

        // R8 abort on unstaged buffer
        halt = 1'b1;
        wr(2'd0, 4'b1100, 11'h3, 4'd1, 64'h3);
        wr(2'd0, 4'b1001, 11'h0, 4'd0, 64'h0);
        code_of(2'd0, c);
        chk(c == 4'b1000 && irq_flag[0], "R8", "immediate abort",
            {c, irq_flag[0]}, {4'b1000, 1'b1});

        // R9 abort overtaken by success
        halt = 1'b0;
        wr(2'd3, 4'b1100, 11'h33, 4'd4, 64'h4);
        @(negedge clk);
        chk(tx_src == 3 && tx_req, "R1", "staged buf3", tx_src, 3);
        wr(2'd3, 4'b1001, 11'h0, 4'd0, 64'h0);
        pulse(0);
        code_of(2'd3, c);
        chk(c == 4'b1000 && irq_flag[3] && !tx_req, "R9", "abort overtaken",
            {c, irq_flag[3], tx_req}, {4'b1000, 1'b1, 1'b0});

        // R4 no lock without aen
        flag_clr = 4'hF; @(negedge clk); flag_clr = 0;
        aen = 1'b0;
        wr(2'd0, 4'b1100, 11'h44, 4'd2, 64'h5);
        @(negedge clk);
        chk(tx_req && tx_src == 0 && lock_vec == 0, "R4", "no lock",
            {tx_req, tx_src, lock_vec}, {1'b1, 2'd0, 4'd0});
        wr(2'd0, 4'b1000, 11'h44, 4'd2, 64'h5);
        code_of(2'd0, c);
        chk(c == 4'b1000, "R4", "write landed", c, 4'b1000);
        pulse(0);
        chk(irq_flag[0] == 1'b0 && !tx_req, "R4", "silent send",
            {irq_flag[0], tx_req}, 0);

        // R7 halt and bus-off release and block staging
        aen = 1'b1;
        wr(2'd1, 4'b1100, 11'h55, 4'd1, 64'h6);
        @(negedge clk);
        chk(lock_vec == 4'b0010, "R7", "locked before halt", lock_vec, 4'b0010);
        bus_off = 1'b1;
        @(negedge clk);
        chk(!tx_req && lock_vec == 0, "R7", "bus-off release", {tx_req, lock_vec}, 0);
        @(negedge clk);
        chk(!tx_req, "R7", "no staging while stopped", tx_req, 0);
        bus_off = 1'b0;
        @(negedge clk);
        chk(tx_req && tx_src == 1, "R7", "restaged after stop", tx_src, 1);

        // R2 payload copy and masking
        halt = 1'b1;
        @(negedge clk);
        all_off();
        wr(2'd2, 4'b1100, 11'h5A3, 4'd3, 64'h8877_6655_4433_2211);
        halt = 1'b0;
        @(negedge clk);
        chk(tx_id == 11'h5A3 && tx_src == 2, "R2", "staged id", tx_id, 11'h5A3);
        chk(tx_data == 64'h0000_0000_0033_2211, "R2", "masked data",
            tx_data, 64'h0000_0000_0033_2211);

        // R10 set wins over clear
        flag_clr = 4'b0100;
        pulse(0);
        flag_clr = 0;
        chk(irq_flag[2] == 1'b1, "R10", "set beats clear", irq_flag, 4'b0100);
        flag_clr = 4'b0100; @(negedge clk); flag_clr = 0;
        chk(irq_flag[2] == 1'b0, "R10", "clear alone", irq_flag, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule